// File: doc/BRIEF.md
# Multi-Channel Circular Buffer Pointer Manager

This block keeps the transmit and receive ring buffers for a set of independent channels. Each direction has its own byte memory, and that memory is split between the channels. At start-up a configuration strobe gives each channel a power-of-two size per direction. Regions are laid out back to back in channel order. Once a layout has been accepted it cannot change until reset.

Software works through a host port. It writes transmit bytes and reads received bytes by pointer value. It moves its own pointer in each direction (the transmit write pointer and the receive read pointer). It then makes a move visible with a SEND or RECV command. A line-side port stands in for the protocol engine: it drains transmit bytes that have been committed and deposits incoming bytes while the channel has room.

All pointers are 16 bits wide and free-running, so space and occupancy are differences taken modulo 2^16. A byte's location is the channel base plus the pointer folded into the channel's window. The pointer owned by the other side can be read but never written.

Top module: `cbm_bufmgr`

## Requirements
- R1: The size code for channel i sits in bits [i*SZW +: SZW] of each code vector. Code 0 means size 0, and code k>0 means MIN_BYTES<<(k-1) bytes. Channel regions are placed consecutively in ascending channel order without overlap. After an accepted load, an idle channel reports transmit free space equal to its size and receive window equal to its size.
- R2: After reset, cfg_ok=0 and cfg_err=0. A load whose per-direction total exceeds DIR_BYTES sets cfg_err=1, leaves cfg_ok=0 and leaves every channel inert. A load that fits sets cfg_ok=1 and clears cfg_err.
- R3: While cfg_ok=1, further loads are ignored and all sizes keep their values.
- R4: A byte stored at pointer p is found at pointer p by the other side, including when p runs past the channel size and the window wraps.
- R5: sta_tx_free equals size − (host write pointer − engine read pointer), taken mod 2^16.
- R6: SEND (h_op=5) commits exactly the bytes from the engine read pointer up to the host write pointer. e_tx_pend stays 0 before SEND and after all committed bytes are popped. A SEND with no new bytes queues nothing. A popped byte appears on e_tx_byte with e_tx_bvalid one cycle after the pop.
- R7: An accepted push stores e_rx_byte and advances the engine write pointer by one. sta_rx_size equals the engine write pointer minus the released read pointer. A host read (h_op=2) returns the byte on h_rdata with h_rvalid one cycle later.
- R8: Setting the host read pointer (h_op=4) changes neither sta_rx_size nor e_rx_window. Only RECV (h_op=6) releases the space.
- R9: e_rx_ready is 0 exactly when the channel holds size unread bytes. A push while it is 0 changes neither the write pointer nor any stored byte.
- R10: Op code 7, which names the engine-owned pointers, has no effect on them.
- R11: e_rx_win equals size − sta_rx_size for the selected channel.
- R12: A channel of size 0 ignores data writes, pointer moves and SEND. It reports 0 free space and never reports pending bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Strobe that applies the size codes |
| cfg_tx_codes | input | NCH*SZW | Transmit size code per channel |
| cfg_rx_codes | input | NCH*SZW | Receive size code per channel |
| cfg_ok | output | 1 | A layout has been accepted |
| cfg_err | output | 1 | The last load was rejected |
| h_ch | input | CW | Host channel select; also selects the sta_* outputs |
| h_op | input | 3 | 0 idle, 1 put tx byte, 2 get rx byte, 3 set tx write ptr, 4 set rx read ptr, 5 SEND, 6 RECV, 7 engine-pointer write (ignored) |
| h_ptr | input | PW | Pointer operand |
| h_wdata | input | 8 | Transmit byte |
| h_rdata | output | 8 | Received byte |
| h_rvalid | output | 1 | h_rdata holds the byte from the previous get |
| sta_tx_free | output | PW | Transmit free space |
| sta_rx_size | output | PW | Unread received bytes |
| sta_tx_rd | output | PW | Engine transmit read pointer |
| sta_rx_wr | output | PW | Engine receive write pointer |
| e_tx_ch | input | CW | Engine transmit channel |
| e_tx_pop | input | 1 | Take one committed byte |
| e_tx_pend | output | 1 | Committed bytes remain |
| e_tx_byte | output | 8 | Popped byte |
| e_tx_bvalid | output | 1 | e_tx_byte holds the byte from the previous pop |
| e_rx_ch | input | CW | Engine receive channel |
| e_rx_push | input | 1 | Deposit one byte |
| e_rx_byte | input | 8 | Deposited byte |
| e_rx_ready | output | 1 | Channel has room |
| e_rx_win | output | PW | Receive free space |

## Verification
The bench fills channels of unequal size side by side over several laps of each window before it drains any of them. An error in base placement or in folding a pointer into the window would let one channel overwrite another, or put a wrapped byte at the wrong place, and the bench would read back the wrong data. It fills every receive channel to the last byte and then pushes once more. A design with an off-by-one full test would either take that byte, overwriting the oldest unread one, or stop one byte short. It also checks that moving the read pointer alone releases nothing, that a repeated SEND queues nothing, and that a rejected layout, a late reload and a zero-size channel leave everything unchanged. A design that released space early, re-queued sent data or let a disabled channel write into its neighbour's region would show a wrong count or a corrupted byte.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

   typedef enum logic [2:0] {
      HOP_IDLE   = 3'd0,
      HOP_TXPUT  = 3'd1,
      HOP_RXGET  = 3'd2,
      HOP_TXWP   = 3'd3,
      HOP_RXRP   = 3'd4,
      HOP_SEND   = 3'd5,
      HOP_RECV   = 3'd6,
      HOP_ENGPTR = 3'd7
   } hop_e;

   // size code -> bytes: 0 disables, k selects min_b << (k-1)
   function automatic logic [31:0] code_bytes(input logic [7:0] code, input int unsigned min_b);
      if (code == 8'd0) return 32'd0;
      return min_b << (code - 8'd1);
   endfunction

endpackage

// File: rtl/cbm_ram.sv
module cbm_ram #(
   parameter int DEPTH = 256,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [7:0]    wd,
   input  logic          re,
   input  logic [AW-1:0] ra,
   output logic [7:0]    rq
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[wa] <= wd;
      if (re) rq <= mem[ra];
   end
endmodule

// File: rtl/cbm_partition.sv
module cbm_partition #(
   parameter int NCH       = 4,
   parameter int SZW       = 3,
   parameter int MIN_BYTES = 16,
   parameter int DIR_BYTES = 256,
   parameter int AW        = $clog2(DIR_BYTES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_load,
   input  logic [NCH*SZW-1:0]     cfg_tx_codes,
   input  logic [NCH*SZW-1:0]     cfg_rx_codes,
   output logic                   run,
   output logic                   err,
   output logic [NCH-1:0][AW:0]   tx_base,
   output logic [NCH-1:0][AW:0]   tx_size,
   output logic [NCH-1:0][AW:0]   rx_base,
   output logic [NCH-1:0][AW:0]   rx_size
);
   import cbm_pkg::*;

   logic [NCH-1:0][31:0] treq, rreq, tpre, rpre;
   logic [31:0]          tsum, rsum;
   logic                 fits;

   // prefix sums give each channel's offset in ascending channel order
   always_comb begin
      tsum = '0;
      rsum = '0;
      for (int i = 0; i < NCH; i++) begin
         treq[i] = code_bytes(8'(cfg_tx_codes[i*SZW +: SZW]), MIN_BYTES);
         rreq[i] = code_bytes(8'(cfg_rx_codes[i*SZW +: SZW]), MIN_BYTES);
         tpre[i] = tsum;
         rpre[i] = rsum;
         tsum    = tsum + treq[i];
         rsum    = rsum + rreq[i];
      end
   end

   assign fits = (tsum <= 32'(DIR_BYTES)) && (rsum <= 32'(DIR_BYTES));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run     <= 1'b0;
         err     <= 1'b0;
         tx_base <= '0;
         tx_size <= '0;
         rx_base <= '0;
         rx_size <= '0;
      end else if (cfg_load && !run) begin
         if (fits) begin
            run <= 1'b1;
            err <= 1'b0;
            for (int i = 0; i < NCH; i++) begin
               tx_base[i] <= (AW+1)'(tpre[i]);
               tx_size[i] <= (AW+1)'(treq[i]);
               rx_base[i] <= (AW+1)'(rpre[i]);
               rx_size[i] <= (AW+1)'(rreq[i]);
            end
         end else begin
            err <= 1'b1;
         end
      end
   end

   // R3: layout frozen once accepted
   a_r3_layout_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> run && $stable(tx_size) && $stable(rx_size) && $stable(tx_base) && $stable(rx_base));

   // R2: a rejection never coexists with a running layout
   a_r2_err_not_run: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !run);
endmodule

// File: rtl/cbm_chan.sv
module cbm_chan #(
   parameter int PW = 16,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_en,
   input  logic          rx_en,
   input  logic [AW:0]   tx_size,
   input  logic [AW:0]   rx_size,
   input  logic          set_txwp,
   input  logic          set_rxrp,
   input  logic          send,
   input  logic          recv,
   input  logic [PW-1:0] h_ptr,
   input  logic          pop,
   input  logic          push,
   output logic [PW-1:0] tx_rd,
   output logic [PW-1:0] rx_wr,
   output logic [PW-1:0] tx_free,
   output logic [PW-1:0] rx_used,
   output logic [PW-1:0] rx_free,
   output logic          tx_pend,
   output logic          rx_ready
);
   logic [PW-1:0] tx_wp, tx_end, rx_rp, rx_rel;
   logic [PW-1:0] tsz, rsz;

   assign tsz      = PW'(tx_size);
   assign rsz      = PW'(rx_size);
   assign tx_free  = tsz - (tx_wp - tx_rd);
   assign rx_used  = rx_wr - rx_rel;
   assign rx_free  = rsz - rx_used;
   assign tx_pend  = tx_en && (tx_end != tx_rd);
   assign rx_ready = rx_en && (rx_used < rsz);

   // host-owned side: shadow pointer plus committed copy
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_wp  <= '0;
         tx_end <= '0;
         rx_rp  <= '0;
         rx_rel <= '0;
      end else begin
         if (set_txwp && tx_en) tx_wp  <= h_ptr;
         if (send && tx_en)     tx_end <= tx_wp;
         if (set_rxrp && rx_en) rx_rp  <= h_ptr;
         if (recv && rx_en)     rx_rel <= rx_rp;
      end
   end

   // engine-owned side: moved only by accepted engine beats
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_rd <= '0;
         rx_wr <= '0;
      end else begin
         if (pop && tx_pend)   tx_rd <= tx_rd + 1'b1;
         if (push && rx_ready) rx_wr <= rx_wr + 1'b1;
      end
   end

   a_r9_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      push && !rx_ready |=> $stable(rx_wr));
   a_r6_end_moves_on_send: assert property (@(posedge clk) disable iff (!rst_n)
      !send |=> $stable(tx_end));
   a_r8_rel_moves_on_recv: assert property (@(posedge clk) disable iff (!rst_n)
      !recv |=> $stable(rx_rel));
   a_r6_no_pop_past_end: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_pend |=> $stable(tx_rd));
   a_r10_txrd_engine_only: assert property (@(posedge clk) disable iff (!rst_n)
      !pop |=> $stable(tx_rd));
   a_r10_rxwr_engine_only: assert property (@(posedge clk) disable iff (!rst_n)
      !push |=> $stable(rx_wr));
endmodule

// File: rtl/cbm_bufmgr.sv
module cbm_bufmgr #(
   parameter int NCH       = 4,
   parameter int SZW       = 3,
   parameter int MIN_BYTES = 16,
   parameter int DIR_BYTES = 256,
   parameter int PW        = 16,
   parameter int CW        = (NCH > 1) ? $clog2(NCH) : 1,
   parameter int AW        = $clog2(DIR_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_load,
   input  logic [NCH*SZW-1:0] cfg_tx_codes,
   input  logic [NCH*SZW-1:0] cfg_rx_codes,
   output logic               cfg_ok,
   output logic               cfg_err,
   input  logic [CW-1:0]      h_ch,
   input  logic [2:0]         h_op,
   input  logic [PW-1:0]      h_ptr,
   input  logic [7:0]         h_wdata,
   output logic [7:0]         h_rdata,
   output logic               h_rvalid,
   output logic [PW-1:0]      sta_tx_free,
   output logic [PW-1:0]      sta_rx_size,
   output logic [PW-1:0]      sta_tx_rd,
   output logic [PW-1:0]      sta_rx_wr,
   input  logic [CW-1:0]      e_tx_ch,
   input  logic               e_tx_pop,
   output logic               e_tx_pend,
   output logic [7:0]         e_tx_byte,
   output logic               e_tx_bvalid,
   input  logic [CW-1:0]      e_rx_ch,
   input  logic               e_rx_push,
   input  logic [7:0]         e_rx_byte,
   output logic               e_rx_ready,
   output logic [PW-1:0]      e_rx_win
);
   import cbm_pkg::*;

   // elaboration checks on the parameter set
   if ((DIR_BYTES & (DIR_BYTES - 1)) != 0) begin : g_bad_dir
      $error("DIR_BYTES must be a power of two");
   end
   if ((MIN_BYTES & (MIN_BYTES - 1)) != 0 || MIN_BYTES > DIR_BYTES) begin : g_bad_min
      $error("MIN_BYTES must be a power of two no larger than DIR_BYTES");
   end
   if (PW <= AW) begin : g_bad_pw
      $error("PW must exceed the region address width");
   end
   if (SZW < 1 || SZW > 8 || NCH < 1) begin : g_bad_cnt
      $error("SZW must be 1..8 and NCH at least 1");
   end

   logic                 run;
   logic [NCH-1:0][AW:0] txb, txs, rxb, rxs;

   cbm_partition #(
      .NCH(NCH), .SZW(SZW), .MIN_BYTES(MIN_BYTES), .DIR_BYTES(DIR_BYTES), .AW(AW)
   ) u_part (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
      .cfg_tx_codes(cfg_tx_codes), .cfg_rx_codes(cfg_rx_codes),
      .run(run), .err(cfg_err),
      .tx_base(txb), .tx_size(txs), .rx_base(rxb), .rx_size(rxs)
   );
   assign cfg_ok = run;

   hop_e op;
   assign op = hop_e'(h_op);

   logic [NCH-1:0]          tx_en, rx_en, tx_pend, rx_ready;
   logic [NCH-1:0][PW-1:0]  tx_rd, rx_wr, tx_free, rx_used, rx_free;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic hsel;
      assign hsel     = (h_ch == CW'(i));
      assign tx_en[i] = run && (txs[i] != '0);
      assign rx_en[i] = run && (rxs[i] != '0);

      cbm_chan #(.PW(PW), .AW(AW)) u_ch (
         .clk(clk), .rst_n(rst_n),
         .tx_en(tx_en[i]), .rx_en(rx_en[i]),
         .tx_size(txs[i]), .rx_size(rxs[i]),
         .set_txwp(hsel && op == HOP_TXWP),
         .set_rxrp(hsel && op == HOP_RXRP),
         .send(hsel && op == HOP_SEND),
         .recv(hsel && op == HOP_RECV),
         .h_ptr(h_ptr),
         .pop(e_tx_pop && e_tx_ch == CW'(i)),
         .push(e_rx_push && e_rx_ch == CW'(i)),
         .tx_rd(tx_rd[i]), .rx_wr(rx_wr[i]),
         .tx_free(tx_free[i]), .rx_used(rx_used[i]), .rx_free(rx_free[i]),
         .tx_pend(tx_pend[i]), .rx_ready(rx_ready[i])
      );
   end

   assign sta_tx_free = tx_free[h_ch];
   assign sta_rx_size = rx_used[h_ch];
   assign sta_tx_rd   = tx_rd[h_ch];
   assign sta_rx_wr   = rx_wr[h_ch];
   assign e_tx_pend   = tx_pend[e_tx_ch];
   assign e_rx_ready  = rx_ready[e_rx_ch];
   assign e_rx_win    = rx_free[e_rx_ch];

   // physical address: channel base plus pointer folded by the power-of-two size
   logic [AW-1:0] h_tx_addr, h_rx_addr, e_tx_addr, e_rx_addr;
   assign h_tx_addr = AW'(txb[h_ch] + ((AW+1)'(h_ptr) & (txs[h_ch] - 1'b1)));
   assign h_rx_addr = AW'(rxb[h_ch] + ((AW+1)'(h_ptr) & (rxs[h_ch] - 1'b1)));
   assign e_tx_addr = AW'(txb[e_tx_ch] + ((AW+1)'(tx_rd[e_tx_ch]) & (txs[e_tx_ch] - 1'b1)));
   assign e_rx_addr = AW'(rxb[e_rx_ch] + ((AW+1)'(rx_wr[e_rx_ch]) & (rxs[e_rx_ch] - 1'b1)));

   logic tx_put, rx_get, pop_ok, push_ok;
   assign tx_put  = (op == HOP_TXPUT) && tx_en[h_ch];
   assign rx_get  = (op == HOP_RXGET) && rx_en[h_ch];
   assign pop_ok  = e_tx_pop && e_tx_pend;
   assign push_ok = e_rx_push && e_rx_ready;

   cbm_ram #(.DEPTH(DIR_BYTES), .AW(AW)) u_txram (
      .clk(clk), .we(tx_put), .wa(h_tx_addr), .wd(h_wdata),
      .re(pop_ok), .ra(e_tx_addr), .rq(e_tx_byte)
   );
   cbm_ram #(.DEPTH(DIR_BYTES), .AW(AW)) u_rxram (
      .clk(clk), .we(push_ok), .wa(e_rx_addr), .wd(e_rx_byte),
      .re(rx_get), .ra(h_rx_addr), .rq(h_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h_rvalid    <= 1'b0;
         e_tx_bvalid <= 1'b0;
      end else begin
         h_rvalid    <= rx_get;
         e_tx_bvalid <= pop_ok;
      end
   end

   // R9 / R11: readiness and reported window agree
   a_r9_ready_has_room: assert property (@(posedge clk) disable iff (!rst_n)
      e_rx_ready |-> e_rx_win != '0);
   // R12: nothing is ever pending on a channel that is not running
   a_r12_idle_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ok |-> !e_tx_pend && !e_rx_ready);
endmodule

// File: tb/cbm_bufmgr_test.sv
module cbm_bufmgr_test;
   localparam int NCH = 4;
   localparam int SZW = 3;
   localparam int PW  = 16;
   localparam int CW  = 2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic               rst_n, cfg_load, cfg_ok, cfg_err;
   logic [NCH*SZW-1:0] cfg_tx_codes, cfg_rx_codes;
   logic [CW-1:0]      h_ch, e_tx_ch, e_rx_ch;
   logic [2:0]         h_op;
   logic [PW-1:0]      h_ptr, sta_tx_free, sta_rx_size, sta_tx_rd, sta_rx_wr, e_rx_win;
   logic [7:0]         h_wdata, h_rdata, e_tx_byte, e_rx_byte;
   logic               h_rvalid, e_tx_pop, e_tx_pend, e_tx_bvalid, e_rx_push, e_rx_ready;

   cbm_bufmgr uut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
      .cfg_tx_codes(cfg_tx_codes), .cfg_rx_codes(cfg_rx_codes),
      .cfg_ok(cfg_ok), .cfg_err(cfg_err),
      .h_ch(h_ch), .h_op(h_op), .h_ptr(h_ptr), .h_wdata(h_wdata),
      .h_rdata(h_rdata), .h_rvalid(h_rvalid),
      .sta_tx_free(sta_tx_free), .sta_rx_size(sta_rx_size),
      .sta_tx_rd(sta_tx_rd), .sta_rx_wr(sta_rx_wr),
      .e_tx_ch(e_tx_ch), .e_tx_pop(e_tx_pop), .e_tx_pend(e_tx_pend),
      .e_tx_byte(e_tx_byte), .e_tx_bvalid(e_tx_bvalid),
      .e_rx_ch(e_rx_ch), .e_rx_push(e_rx_push), .e_rx_byte(e_rx_byte),
      .e_rx_ready(e_rx_ready), .e_rx_win(e_rx_win)
   );

   int checks = 0;
   int fails  = 0;
   int txsz[4] = '{16, 32, 0, 64};
   int rxsz[4] = '{16, 128, 64, 32};
   int txwp[4], txrd[4], rxwr[4], rxrel[4];

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] tpat(int ch, int p);
      return 8'(ch * 61 + p * 7 + 3);
   endfunction
   function automatic logic [7:0] rpat(int ch, int p);
      return 8'(ch * 29 + p * 11 + 1);
   endfunction

   task automatic hop(int ch, int op, int ptr, logic [7:0] d);
      @(negedge clk);
      h_ch = CW'(ch); h_op = 3'(op); h_ptr = PW'(ptr); h_wdata = d;
      @(negedge clk);
      h_op = 3'd0;
   endtask

   task automatic peek(int ch);
      h_ch = CW'(ch); e_tx_ch = CW'(ch); e_rx_ch = CW'(ch);
      #1;
   endtask

   task automatic epop(int ch, logic [7:0] exp);
      @(negedge clk);
      e_tx_ch = CW'(ch); e_tx_pop = 1'b1;
      @(negedge clk);
      e_tx_pop = 1'b0;
      chk("R6 pop strobe", int'(e_tx_bvalid), 1);
      chk("R4 tx byte after wrap", int'(e_tx_byte), int'(exp));
   endtask

   task automatic epush(int ch, logic [7:0] b);
      @(negedge clk);
      e_rx_ch = CW'(ch); e_rx_push = 1'b1; e_rx_byte = b;
      @(negedge clk);
      e_rx_push = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cfg_load = 1'b0; cfg_tx_codes = '0; cfg_rx_codes = '0;
      h_ch = '0; h_op = '0; h_ptr = '0; h_wdata = '0;
      e_tx_ch = '0; e_tx_pop = 1'b0; e_rx_ch = '0; e_rx_push = 1'b0; e_rx_byte = '0;
      for (int i = 0; i < 4; i++) begin
         txwp[i] = 0; txrd[i] = 0; rxwr[i] = 0; rxrel[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R2 reset ok", int'(cfg_ok), 0);
      chk("R2 reset err", int'(cfg_err), 0);
      chk("R2 reset ready", int'(e_rx_ready), 0);
      chk("R7 reset rvalid", int'(h_rvalid), 0);

      // oversize transmit layout: four regions of 256 bytes
      @(negedge clk);
      cfg_tx_codes = {4{3'd5}};
      cfg_rx_codes = {3'd2, 3'd3, 3'd4, 3'd1};
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      peek(1);
      chk("R2 reject err", int'(cfg_err), 1);
      chk("R2 reject ok", int'(cfg_ok), 0);
      chk("R2 reject ready", int'(e_rx_ready), 0);
      epush(1, 8'h55);
      peek(1);
      chk("R2 reject push", int'(sta_rx_wr), 0);

      // accepted layout
      @(negedge clk);
      cfg_tx_codes = {3'd3, 3'd0, 3'd2, 3'd1};
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      #1;
      chk("R2 accept ok", int'(cfg_ok), 1);
      chk("R2 accept err", int'(cfg_err), 0);
      for (int c = 0; c < 4; c++) begin
         peek(c);
         chk("R1 tx size", int'(sta_tx_free), txsz[c]);
         chk("R1 rx size", int'(e_rx_win), rxsz[c]);
         chk("R1 ready", int'(e_rx_ready), 1);
      end

      // reload while running
      @(negedge clk);
      cfg_tx_codes = {4{3'd1}}; cfg_rx_codes = {4{3'd1}};
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      peek(1);
      chk("R3 ok held", int'(cfg_ok), 1);
      chk("R3 tx size held", int'(sta_tx_free), 32);
      chk("R3 rx size held", int'(e_rx_win), 128);

      // zero-size channel 2 sits between channels 1 and 3
      hop(2, 1, 0, 8'hAA);
      hop(2, 3, 5, 8'h00);
      hop(2, 5, 0, 8'h00);
      peek(2);
      chk("R12 no pend", int'(e_tx_pend), 0);
      chk("R12 no free", int'(sta_tx_free), 0);

      // transmit sweep: all channels filled before any is drained
      for (int r = 0; r < 3; r++) begin
         for (int c = 0; c < 4; c++) begin
            if (txsz[c] == 0) continue;
            for (int k = 0; k < txsz[c] * 3 / 4; k++)
               hop(c, 1, txwp[c] + k, tpat(c, txwp[c] + k));
            txwp[c] += txsz[c] * 3 / 4;
            hop(c, 3, txwp[c], 8'h00);
            peek(c);
            chk("R5 tx free", int'(sta_tx_free), txsz[c] - (txwp[c] - txrd[c]));
            chk("R6 no pend before send", int'(e_tx_pend), 0);
            hop(c, 5, 0, 8'h00);
            peek(c);
            chk("R6 pend after send", int'(e_tx_pend), 1);
         end
         for (int c = 0; c < 4; c++) begin
            if (txsz[c] == 0) continue;
            while (txrd[c] < txwp[c]) begin
               epop(c, tpat(c, txrd[c]));
               txrd[c]++;
            end
            peek(c);
            chk("R6 drained", int'(e_tx_pend), 0);
            chk("R5 free restored", int'(sta_tx_free), txsz[c]);
            chk("R5 engine ptr", int'(sta_tx_rd), txrd[c]);
            hop(c, 5, 0, 8'h00);
            peek(c);
            chk("R6 empty send", int'(e_tx_pend), 0);
         end
      end

      // host attempt on engine-owned pointers
      hop(1, 7, 16'h1234, 8'h00);
      peek(1);
      chk("R10 tx rd kept", int'(sta_tx_rd), txrd[1]);
      chk("R10 rx wr kept", int'(sta_rx_wr), 0);
      chk("R10 no pend", int'(e_tx_pend), 0);

      // receive sweep
      for (int r = 0; r < 3; r++) begin
         for (int c = 0; c < 4; c++) begin
            for (int g = 0; g <= 256; g++) begin
               peek(c);
               chk("R11 window", int'(e_rx_win), rxsz[c] - (rxwr[c] - rxrel[c]));
               chk("R9 ready", int'(e_rx_ready), int'((rxwr[c] - rxrel[c]) < rxsz[c]));
               if ((rxwr[c] - rxrel[c]) >= rxsz[c]) break;
               epush(c, rpat(c, rxwr[c]));
               rxwr[c]++;
            end
            epush(c, 8'hEE);
            peek(c);
            chk("R9 full push dropped", int'(sta_rx_wr), rxwr[c]);
            chk("R7 rx size full", int'(sta_rx_size), rxsz[c]);
         end
         for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < rxsz[c] * 3 / 4; k++) begin
               hop(c, 2, rxrel[c] + k, 8'h00);
               chk("R7 read strobe", int'(h_rvalid), 1);
               chk("R7 rx byte", int'(h_rdata), int'(rpat(c, rxrel[c] + k)));
            end
            hop(c, 4, rxrel[c] + rxsz[c] * 3 / 4, 8'h00);
            peek(c);
            chk("R8 size before recv", int'(sta_rx_size), rxsz[c]);
            chk("R8 window before recv", int'(e_rx_win), 0);
            hop(c, 6, 0, 8'h00);
            rxrel[c] += rxsz[c] * 3 / 4;
            peek(c);
            chk("R8 size after recv", int'(sta_rx_size), rxwr[c] - rxrel[c]);
            chk("R11 window after recv", int'(e_rx_win), rxsz[c] - (rxwr[c] - rxrel[c]));
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule